// File: doc/BRIEF.md
# Random Number Generator Control and Interrupt Unit

This block is the register front end of an on-chip random number generator. Software reaches it through a plain 32-bit register bus with separate read and write strobes. Through this bus, software starts a self-test or a seed generation, sets interrupt masks, and enables automatic reseeding. It also reads the status, the error code and the random words. A small internal model stands in for the entropy source and for the test logic. A 32-bit LFSR supplies the words, and two injection inputs force a self-test failure or a statistical failure at the end of an operation.

A sequencer with four states drives the operations:
- `SQ_IDLE` is unseeded and produces no words.
- `SQ_SELFTEST` and `SQ_SEED` are the busy states. Each one is timed by a down-counter.
- `SQ_RUN` is seeded. In this state the FIFO is filled one word per cycle while it has room and no error is pending.

The transitions are:
- `start_selftest` goes from `SQ_IDLE` or `SQ_RUN` to `SQ_SELFTEST`.
- `start_seed` goes from `SQ_IDLE` or `SQ_RUN` to `SQ_SEED`.
- `auto_reseed` goes from `SQ_RUN` to `SQ_SEED`.
- `selftest_end` goes from `SQ_SELFTEST` to `SQ_IDLE`.
- `seed_ok` goes from `SQ_SEED` to `SQ_RUN`.
- `seed_fail` goes from `SQ_SEED` to `SQ_IDLE`.

If both start bits are written together, the seed wins. Completion sets a sticky done flag, and any failure sets an error code. The interrupt line combines these flags with the masks.

Top module: `rng_ctl_unit`

## Requirements
- R1: After reset, the identification register holds the type code in bits 31:28 (1 = B-type, 2 = C-type), the major revision in bits 15:8 and the minor revision in bits 7:0. Every other register reads zero and `irq_o` is low.
- R2: The register byte offsets are:
  - identification: 0x00
  - command: 0x04
  - control: 0x08. Bit 4 enables automatic reseeding, bit 5 masks the done interrupt and bit 6 masks the error interrupt. These three bits read back as written.
  - status: 0x0C. Bit 4 is self-test done, bit 5 is seed done, bits 11:8 hold the FIFO level and bit 16 is the error flag.
  - error code: 0x10
  - FIFO read port: 0x14

  Reads take effect one cycle after the read strobe.
- R3: The command register bits are one-cycle pulses and always read zero:
  - bit 0 starts a self-test
  - bit 1 starts seeding
  - bit 4 is clear-interrupt
  - bit 5 is clear-error
- R4: A start command written while a self-test or seeding is in progress is ignored.
- R5: A self-test lasts ST_CYCLES cycles, then sets self-test done and leaves the generator unseeded. If `selftest_fail_i` is high when it finishes, the error code becomes 0x00000001.
- R6: Clear-interrupt clears both done flags only when the error code is zero. Otherwise it has no effect.
- R7: Clear-error, when the error code is nonzero, clears the error code and both done flags. When the error code is zero, it has no effect.
- R8: `irq_o` = (any done flag AND NOT done mask) OR (error flag AND NOT error mask). A masked source still sets its status bit.
- R9: Seeding lasts SEED_CYCLES cycles and sets seed done. If `statfail_i` is high at the end, the error code becomes 0x00000008 and the generator stays unseeded. Otherwise it becomes seeded.
- R10: While seeded and error-free, the FIFO fills to FIFO_DEPTH words (at most 15). A FIFO read returns a nonzero word and lowers the level by one.
- R11: A FIFO read returns zero and leaves the level unchanged when the FIFO is empty or when an error is pending.
- R12: A counter records the words popped since the last seed start, whether or not automatic reseeding is enabled. While automatic reseeding is enabled and the generator is seeded, reaching RESEED_RESULTS×WORDS_PER_RESULT starts a reseed with no command. While it is disabled, no reseed starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| selftest_fail_i | input | 1 | Forces a self-test failure at completion |
| statfail_i | input | 1 | Forces a statistical failure at seed completion |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with the following parameters:

| Parameter | Value |
|---|---|
| FIFO_DEPTH | 4 |
| ST_CYCLES | 6 |
| SEED_CYCLES | 10 |
| RESEED_RESULTS | 2 |
| WORDS_PER_RESULT | 5 |

A ten-word reseed threshold brings the automatic reseed within a handful of FIFO reads, where the default threshold would take over five million. A four-word FIFO lets the bench fill it, drain it and read it empty within a few dozen cycles. The short operation timers keep each self-test and seed to a few register polls.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SELFTEST,
        SQ_SEED,
        SQ_RUN
    } seq_state_t;

    // register byte offsets
    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_ERR  = 8'h10;
    localparam logic [7:0] OFS_FIFO = 8'h14;

    localparam logic [31:0] ERRC_SELFTEST = 32'h0000_0001;
    localparam logic [31:0] ERRC_STAT     = 32'h0000_0008;

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] TAPS = 32'h8020_0003,
    parameter logic [31:0] INIT = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_q;

    // Galois form, never reaches the all-zero state from a nonzero start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= INIT[W-1:0];
        else        sr_q <= (sr_q >> 1) ^ ({W{sr_q[0]}} & TAPS[W-1:0]);
    end

    assign word_o = sr_q;
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] lvl_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            if (push && !pop)      lvl_q <= lvl_q + 1'b1;
            else if (pop && !push) lvl_q <= lvl_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    assign head  = mem[rp_q];
    assign level = lvl_q;
    assign full  = (lvl_q == LW'(DEPTH));
    assign empty = (lvl_q == '0);
endmodule

// File: rtl/rng_seq.sv
module rng_seq
    import rng_ctl_pkg::*;
#(
    parameter int ST_CYCLES    = 64,
    parameter int SEED_CYCLES  = 256,
    parameter int RESEED_WORDS = 5 * (1 << 20)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_cmd,
    input  logic       seed_cmd,
    input  logic       auto_en,
    input  logic       stat_fail,
    input  logic       word_served,
    output seq_state_t state_o,
    output logic       st_fin,
    output logic       seed_fin
);
    localparam int MAXC = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES;
    localparam int TW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam int CW   = $clog2(RESEED_WORDS + 1);

    seq_state_t    state_q, nxt;
    logic [TW-1:0] tmr_q;
    logic [CW-1:0] served_q;
    logic          go_st, go_seed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            tmr_q    <= '0;
            served_q <= '0;
        end else begin
            state_q <= nxt;
            if (go_st)            tmr_q <= TW'(ST_CYCLES - 1);
            else if (go_seed)     tmr_q <= TW'(SEED_CYCLES - 1);
            else if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
            if (go_seed)
                served_q <= '0;
            else if (word_served && served_q < CW'(RESEED_WORDS))
                served_q <= served_q + 1'b1;
        end
    end

    always_comb begin
        nxt      = state_q;
        go_st    = 1'b0;
        go_seed  = 1'b0;
        st_fin   = 1'b0;
        seed_fin = 1'b0;
        unique case (state_q)
            SQ_IDLE, SQ_RUN: begin
                if (seed_cmd) begin                  // start_seed
                    nxt = SQ_SEED; go_seed = 1'b1;
                end else if (st_cmd) begin           // start_selftest
                    nxt = SQ_SELFTEST; go_st = 1'b1;
                end else if (state_q == SQ_RUN && auto_en &&
                             served_q >= CW'(RESEED_WORDS)) begin
                    nxt = SQ_SEED; go_seed = 1'b1;   // auto_reseed
                end
            end
            SQ_SELFTEST: begin
                if (tmr_q == '0) begin               // selftest_end
                    st_fin = 1'b1; nxt = SQ_IDLE;
                end
            end
            SQ_SEED: begin
                if (tmr_q == '0) begin               // seed_ok / seed_fail
                    seed_fin = 1'b1;
                    nxt = stat_fail ? SQ_IDLE : SQ_RUN;
                end
            end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rng_ctl_unit.sv
module rng_ctl_unit
    import rng_ctl_pkg::*;
#(
    parameter int          FIFO_DEPTH       = 8,
    parameter int          ST_CYCLES        = 64,
    parameter int          SEED_CYCLES      = 256,
    parameter int          RESEED_RESULTS   = 1 << 20,
    parameter int          WORDS_PER_RESULT = 5,
    parameter logic [3:0]  TYPE_CODE        = 4'd2,
    parameter logic [7:0]  REV_MAJ          = 8'd1,
    parameter logic [7:0]  REV_MIN          = 8'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic        bus_rd_en,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        selftest_fail_i,
    input  logic        statfail_i,
    output logic        irq_o
);
    localparam int RESEED_WORDS = RESEED_RESULTS * WORDS_PER_RESULT;
    localparam int LW           = $clog2(FIFO_DEPTH + 1);

    seq_state_t    seq_state;
    logic          st_fin, seed_fin;
    logic          auto_q, mdone_q, merr_q;
    logic          st_done_q, seed_done_q;
    logic [31:0]   err_q, err_new;
    logic          err_flag;
    logic          wr_cmd, st_cmd, seed_cmd, clr_int, clr_err, clr_done;
    logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [31:0]   fifo_head, rnd_word, rd_val, rdata_q;
    logic [LW-1:0] fifo_level;
    logic          wdata_unused;

    assign wdata_unused = ^{bus_wdata[31:7], bus_wdata[3:2]};

    assign wr_cmd   = bus_wr_en && (bus_addr == OFS_CMD);
    assign st_cmd   = wr_cmd && bus_wdata[0];
    assign seed_cmd = wr_cmd && bus_wdata[1];
    assign clr_int  = wr_cmd && bus_wdata[4];
    assign clr_err  = wr_cmd && bus_wdata[5];
    assign err_flag = (err_q != '0);
    assign clr_done = (clr_err && err_flag) || (clr_int && !err_flag);

    assign fifo_push = (seq_state == SQ_RUN) && !fifo_full && !err_flag;
    assign fifo_pop  = bus_rd_en && (bus_addr == OFS_FIFO) && !fifo_empty && !err_flag;

    rng_seq #(
        .ST_CYCLES    (ST_CYCLES),
        .SEED_CYCLES  (SEED_CYCLES),
        .RESEED_WORDS (RESEED_WORDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_cmd      (st_cmd),
        .seed_cmd    (seed_cmd),
        .auto_en     (auto_q),
        .stat_fail   (statfail_i),
        .word_served (fifo_pop),
        .state_o     (seq_state),
        .st_fin      (st_fin),
        .seed_fin    (seed_fin)
    );

    rng_lfsr u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_o (rnd_word)
    );

    rng_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (rnd_word),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        err_new = '0;
        if (st_fin && selftest_fail_i) err_new = err_new | ERRC_SELFTEST;
        if (seed_fin && statfail_i)    err_new = err_new | ERRC_STAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q      <= 1'b0;
            mdone_q     <= 1'b0;
            merr_q      <= 1'b0;
            st_done_q   <= 1'b0;
            seed_done_q <= 1'b0;
            err_q       <= '0;
        end else begin
            if (bus_wr_en && bus_addr == OFS_CTRL) begin
                auto_q  <= bus_wdata[4];
                mdone_q <= bus_wdata[5];
                merr_q  <= bus_wdata[6];
            end
            st_done_q   <= st_fin   || (st_done_q   && !clr_done);
            seed_done_q <= seed_fin || (seed_done_q && !clr_done);
            err_q       <= ((clr_err && err_flag) ? '0 : err_q) | err_new;
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (bus_addr)
            OFS_ID:   rd_val = {TYPE_CODE, 12'd0, REV_MAJ, REV_MIN};
            OFS_CTRL: rd_val = {25'd0, merr_q, mdone_q, auto_q, 4'd0};
            OFS_STAT: rd_val = {15'd0, err_flag, 4'd0, 4'(fifo_level),
                                2'd0, seed_done_q, st_done_q, 4'd0};
            OFS_ERR:  rd_val = err_q;
            OFS_FIFO: rd_val = fifo_pop ? fifo_head : '0;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (bus_rd_en) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign irq_o = ((st_done_q || seed_done_q) && !mdone_q) || (err_flag && !merr_q);
endmodule

// File: rtl/rng_ctl_chk.sv
module rng_ctl_chk
    import rng_ctl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd_en,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          irq_o,
    input seq_state_t    seq_state,
    input logic          st_fin,
    input logic          seed_fin,
    input logic          mdone_q,
    input logic          merr_q,
    input logic          err_flag,
    input logic          clr_int,
    input logic          clr_err,
    input logic          st_done_q,
    input logic          seed_done_q,
    input logic [LW-1:0] fifo_level
);
    // R3
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en && bus_addr == OFS_CMD |=> bus_rdata == 32'd0);

    // R4
    seed_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == SQ_SEED && !seed_fin |=> seq_state == SQ_SEED);

    // R4
    selftest_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == SQ_SELFTEST && !st_fin |=> seq_state == SQ_SELFTEST);

    // R8
    irq_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdone_q && merr_q |-> !irq_o);

    // R6
    clr_int_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && clr_int && !clr_err && (seq_state == SQ_IDLE || seq_state == SQ_RUN)
        |=> $stable({st_done_q, seed_done_q}));

    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    // R11
    err_read_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && bus_rd_en && bus_addr == OFS_FIFO |=> $stable(fifo_level));
endmodule

bind rng_ctl_unit rng_ctl_chk #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd_en   (bus_rd_en),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .seq_state   (seq_state),
    .st_fin      (st_fin),
    .seed_fin    (seed_fin),
    .mdone_q     (mdone_q),
    .merr_q      (merr_q),
    .err_flag    (err_flag),
    .clr_int     (clr_int),
    .clr_err     (clr_err),
    .st_done_q   (st_done_q),
    .seed_done_q (seed_done_q),
    .fifo_level  (fifo_level)
);

// File: tb/rng_ctl_unit_bench.sv
module rng_ctl_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        selftest_fail_i = 1'b0;
    logic        statfail_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        bit          nz;
        string       tag;
    } item_t;
    item_t sbq[$];
    logic  sb_on = 1'b0;
    logic  pend = 1'b0;

    always #10 clk = ~clk;

    rng_ctl_unit #(
        .FIFO_DEPTH(4), .ST_CYCLES(6), .SEED_CYCLES(10),
        .RESEED_RESULTS(2), .WORDS_PER_RESULT(5)
    ) u_rng_ctl_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .selftest_fail_i(selftest_fail_i), .statfail_i(statfail_i), .irq_o(irq_o)
    );

    // monitor: one scoreboard item per checked read
    always @(posedge clk) pend <= bus_rd_en && sb_on;

    always @(negedge clk) begin
        if (pend) begin
            item_t it;
            bit ok;
            it = sbq.pop_front();
            checks++;
            ok = it.nz ? (bus_rdata != 0) : ((bus_rdata & it.mask) == it.exp);
            if (!ok) begin
                fails++;
                if (it.nz)
                    $display("FAIL %s actual=%h expected=nonzero", it.tag, bus_rdata);
                else
                    $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata & it.mask, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e,
                             input logic [31:0] m, input bit nz, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.mask = m; it.nz = nz; it.tag = tag;
        sbq.push_back(it);
        sb_on = 1'b1; bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0; sb_on = 1'b0;
    endtask

    task automatic rd_raw(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic poll_status(input logic [31:0] m, input string tag);
        logic [31:0] v;
        bit hit = 0;
        for (int i = 0; i < 100 && !hit; i++) begin
            rd_raw(8'h0C, v);
            hit = ((v & m) != 0);
        end
        checks++;
        if (!hit) begin
            fails++;
            $display("FAIL %s actual=%h expected=bit %h set", tag, v, m);
        end
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq_o !== e) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, irq_o, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        expect_rd(8'h00, 32'h2000_0103, '1, 0, "R1 id");
        expect_rd(8'h0C, 32'h0, '1, 0, "R1 status");
        expect_rd(8'h08, 32'h0, '1, 0, "R1 ctrl");
        expect_rd(8'h10, 32'h0, '1, 0, "R1 err");
        expect_rd(8'h14, 32'h0, '1, 0, "R11 empty fifo");
        check_irq(1'b0, "R1 irq");
        // passing self-test
        wr(8'h04, 32'h1);
        expect_rd(8'h04, 32'h0, '1, 0, "R3 cmd reads zero");
        poll_status(32'h10, "R5 selftest done");
        expect_rd(8'h0C, 32'h10, '1, 0, "R5 status after pass");
        check_irq(1'b1, "R8 done irq");
        wr(8'h04, 32'h20);
        expect_rd(8'h0C, 32'h10, '1, 0, "R7 clr-err without error");
        wr(8'h04, 32'h10);
        expect_rd(8'h0C, 32'h0, '1, 0, "R6 clr-int clears");
        check_irq(1'b0, "R6 irq cleared");
        // failing self-test, masked
        wr(8'h08, 32'h60);
        expect_rd(8'h08, 32'h60, '1, 0, "R2 ctrl readback");
        selftest_fail_i = 1'b1;
        wr(8'h04, 32'h1);
        poll_status(32'h10, "R5 selftest done on fail");
        selftest_fail_i = 1'b0;
        expect_rd(8'h0C, 32'h1_0010, '1, 0, "R5 error flag");
        expect_rd(8'h10, 32'h1, '1, 0, "R5 selftest error code");
        check_irq(1'b0, "R8 masked");
        wr(8'h08, 32'h0);
        check_irq(1'b1, "R8 unmasked");
        wr(8'h04, 32'h10);
        expect_rd(8'h0C, 32'h1_0010, '1, 0, "R6 clr-int ignored with error");
        wr(8'h04, 32'h20);
        expect_rd(8'h0C, 32'h0, '1, 0, "R7 clr-err clears flags");
        expect_rd(8'h10, 32'h0, '1, 0, "R7 clr-err clears code");
        // seeding with statistical failure, then success
        statfail_i = 1'b1;
        wr(8'h04, 32'h2);
        poll_status(32'h20, "R9 seed done on fail");
        statfail_i = 1'b0;
        expect_rd(8'h10, 32'h8, '1, 0, "R9 stat error code");
        idle(6);
        expect_rd(8'h0C, 32'h1_0020, '1, 0, "R9 unseeded no fill");
        wr(8'h04, 32'h20);
        wr(8'h04, 32'h2);
        poll_status(32'h20, "R9 seed done");
        idle(8);
        expect_rd(8'h0C, 32'h420, '1, 0, "R10 fifo full level");
        // busy ignore
        wr(8'h04, 32'h10);
        wr(8'h04, 32'h2);
        wr(8'h04, 32'h1);
        poll_status(32'h20, "R4 seed done");
        idle(12);
        expect_rd(8'h0C, 32'h20, 32'h30, 0, "R4 selftest ignored while busy");
        // reads, auto reseed off
        wr(8'h04, 32'h10);
        for (int i = 0; i < 10; i++)
            expect_rd(8'h14, 32'h0, 32'h0, 1, "R10 random word");
        idle(20);
        expect_rd(8'h0C, 32'h400, 32'hF30, 0, "R12 no reseed when disabled");
        // auto reseed on
        wr(8'h08, 32'h10);
        poll_status(32'h20, "R12 auto reseed");
        idle(8);
        expect_rd(8'h0C, 32'h400, 32'hF00, 0, "R10 refill after reseed");
        // error blocks reads, then empty reads
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h10);
        selftest_fail_i = 1'b1;
        wr(8'h04, 32'h1);
        poll_status(32'h10, "R5 selftest done");
        selftest_fail_i = 1'b0;
        expect_rd(8'h14, 32'h0, '1, 0, "R11 read under error");
        expect_rd(8'h0C, 32'h1_0400, 32'h1_0F00, 0, "R11 level kept under error");
        wr(8'h04, 32'h20);
        for (int i = 0; i < 4; i++)
            expect_rd(8'h14, 32'h0, 32'h0, 1, "R10 drain word");
        expect_rd(8'h14, 32'h0, '1, 0, "R11 empty read");
        expect_rd(8'h0C, 32'h0, 32'hF00, 0, "R11 level zero");
        idle(2);
        finish_run();
    end
endmodule